// File: doc/BRIEF.md
# Serial Controller Page DMA Engine

This block moves characters between channel A of a two-channel serial controller and word-addressed memory, one 32-bit word per step. A transfer begins with a one-cycle start strobe that carries a start address and a direction. In the transmit direction, the engine reads a word from memory. It hands one byte of that word to the transmitter, and can also hand the same byte back into the receive queue when loopback is on. In the receive direction, the engine pops a character from the receive queue of channel A and stores it in memory as a full word, with the character copied into every byte lane.

No length counter is used. A transfer runs until the stepped address lands on a fixed page boundary, which is 4 KB for transmit and 2 KB for receive. A receive transfer also stops early when the queue runs dry. At the end, a one-cycle done pulse is raised together with a byte count. Every memory access is a request that is held until the memory raises ready.

Top module: `scc_page_dma`

## Requirements
- R1: After reset the engine is idle: no memory request, no queue pop, no transmit byte, done low and byte count zero.
- R2: A start strobe is accepted only while idle. The two low bits of the start address are ignored, so the first access goes to the word-aligned address. A request holds its address and direction stable until ready is seen.
- R3: In transmit (direction input 0), each step is a memory read (write-enable 0). In the cycle where the read completes (request and ready both high), the transmitter strobe is high and the transmit byte equals bits [15:8] of the read data.
- R4: After each completed access the address advances by 4. A transmit transfer ends after the word whose stepped address has bits [11:2] all zero, so a start on a 4 KB boundary moves 1024 words.
- R5: When the loopback input is high at a completing transmit read, a queue push strobe is raised in the same cycle, carrying the transmitted byte. With loopback low, no push is raised.
- R6: In receive (direction input 1), each step pops one character while the queue reports non-empty. The character is then written (write-enable 1) with its value in all four byte lanes of the write data.
- R7: A receive transfer ends when the queue is empty at the start of a step. If the queue is empty at start, no memory write is made and the count is 0.
- R8: A receive transfer also ends after the word whose stepped address has bits [10:2] all zero (a 2 KB boundary).
- R9: The byte count reads the number of bytes sent for transmit and four times the words written for receive. It is valid with done and is held until the next accepted start.
- R10: Done is high for exactly one cycle per transfer. A start strobe that arrives during a transfer changes neither its addresses nor its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle transfer start strobe |
| start_addr_i | input | AW | Start byte address (low two bits ignored) |
| dir_rx_i | input | 1 | 0 = transmit (memory to serial), 1 = receive (queue to memory) |
| loopback_i | input | 1 | Local loopback enable for transmit |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes in a cycle with request and ready high |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Byte to the transmitter |
| rxq_nonempty_i | input | 1 | Channel A receive queue holds a character |
| rxq_data_i | input | 8 | Head character of the channel A queue |
| rxq_pop_o | output | 1 | Pop the head character |
| lb_push_o | output | 1 | Loopback push into the channel A queue |
| lb_byte_o | output | 8 | Byte pushed on loopback |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| byte_count_o | output | CW | Bytes moved by the last transfer |

## Verification
The bench runs transmit transfers from a page start and from the last few words of a page, using a start address whose low bits are set. A design that tests the boundary before stepping, or on the wrong address bits, moves a word too many or ends at 2 KB rather than 4 KB. Receive runs cover an empty queue, a queue that empties mid-page, and a queue that outlasts the remaining half page. These catch an engine that writes a stale word or ignores either stop rule. Every completed access is checked for address, lane 1 selection, lane copying and loopback, and a stray start strobe is injected mid-transfer to catch an engine that restarts.

// File: rtl/scc_dma_pkg.sv
`timescale 1ns/1ps
package scc_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_POLL  = 3'd2,
    ST_STORE = 3'd3,
    ST_FIN   = 3'd4
  } dma_state_e;

  // copy a character into every lane of a 32-bit word
  function automatic logic [31:0] splat_byte(input logic [7:0] ch);
    return {4{ch}};
  endfunction

  // bytes credited for one completed step
  function automatic logic [2:0] step_bytes(input logic rx_mode);
    return rx_mode ? 3'd4 : 3'd1;
  endfunction

endpackage

// File: rtl/scc_dma_addr.sv
`timescale 1ns/1ps
module scc_dma_addr #(
  parameter int AW           = 32,
  parameter int TX_PAGE_BITS = 12,
  parameter int RX_PAGE_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          rx_mode,
  output logic [AW-1:0] addr,
  output logic          wrap_next
);

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(4);
  endfunction

  // true when the word index bits below the page size are all zero
  function automatic logic page_start(input logic [AW-1:0] a, input int unsigned bits);
    logic [AW-1:0] m;
    m = ((AW'(1) << bits) - AW'(1)) & ~AW'(3);
    return (a & m) == '0;
  endfunction

  assign wrap_next = page_start(next_word(addr), rx_mode ? RX_PAGE_BITS : TX_PAGE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= {load_addr[AW-1:2], 2'b00};
    else if (step) addr <= next_word(addr);
  end

endmodule

// File: rtl/scc_dma_count.sv
`timescale 1ns/1ps
module scc_dma_count #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          rx_mode,
  output logic [CW-1:0] count
);
  import scc_dma_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (inc)   count <= count + CW'(step_bytes(rx_mode));
  end

endmodule

// File: rtl/scc_dma_ctrl.sv
`timescale 1ns/1ps
module scc_dma_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dir_rx,
  input  logic mem_ready,
  input  logic rxq_nonempty,
  input  logic wrap_next,
  output logic rx_mode,
  output logic load,
  output logic step,
  output logic mem_req,
  output logic mem_we,
  output logic pop,
  output logic poll_now,
  output logic done
);
  import scc_dma_pkg::*;

  dma_state_e state, nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    step     = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    pop      = 1'b0;
    poll_now = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        load = 1'b1;
        nxt  = dir_rx ? ST_POLL : ST_FETCH;
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          step = 1'b1;
          nxt  = wrap_next ? ST_FIN : ST_FETCH;
        end
      end
      ST_POLL: begin
        poll_now = 1'b1;
        if (rxq_nonempty) begin
          pop = 1'b1;
          nxt = ST_STORE;
        end else begin
          nxt = ST_FIN;
        end
      end
      ST_STORE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready) begin
          step = 1'b1;
          nxt  = wrap_next ? ST_FIN : ST_POLL;
        end
      end
      ST_FIN: begin
        done = 1'b1;
        nxt  = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rx_mode <= 1'b0;
    end else begin
      state <= nxt;
      if (load) rx_mode <= dir_rx;
    end
  end

endmodule

// File: rtl/scc_page_dma.sv
`timescale 1ns/1ps
module scc_page_dma #(
  parameter int AW           = 32,
  parameter int TX_PAGE_BITS = 12,
  parameter int RX_PAGE_BITS = 11,
  localparam int TX_CW = TX_PAGE_BITS - 1,
  localparam int RX_CW = RX_PAGE_BITS + 1,
  localparam int CW    = (TX_CW > RX_CW) ? TX_CW : RX_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          dir_rx_i,
  input  logic          loopback_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_byte_o,
  input  logic          rxq_nonempty_i,
  input  logic [7:0]    rxq_data_i,
  output logic          rxq_pop_o,
  output logic          lb_push_o,
  output logic [7:0]    lb_byte_o,
  output logic          done_o,
  output logic [CW-1:0] byte_count_o
);
  import scc_dma_pkg::*;

  logic       rx_mode, load_evt, step_evt, wrap_evt, poll_now, tx_fire;
  logic [7:0] rx_char;

  scc_dma_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start_i),
    .dir_rx       (dir_rx_i),
    .mem_ready    (mem_ready_i),
    .rxq_nonempty (rxq_nonempty_i),
    .wrap_next    (wrap_evt),
    .rx_mode      (rx_mode),
    .load         (load_evt),
    .step         (step_evt),
    .mem_req      (mem_req_o),
    .mem_we       (mem_we_o),
    .pop          (rxq_pop_o),
    .poll_now     (poll_now),
    .done         (done_o)
  );

  scc_dma_addr #(
    .AW           (AW),
    .TX_PAGE_BITS (TX_PAGE_BITS),
    .RX_PAGE_BITS (RX_PAGE_BITS)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .load_addr (start_addr_i),
    .step      (step_evt),
    .rx_mode   (rx_mode),
    .addr      (mem_addr_o),
    .wrap_next (wrap_evt)
  );

  scc_dma_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load_evt),
    .inc     (step_evt),
    .rx_mode (rx_mode),
    .count   (byte_count_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_char <= '0;
    else if (rxq_pop_o) rx_char <= rxq_data_i;
  end

  assign mem_wdata_o = splat_byte(rx_char);
  assign tx_fire     = step_evt & ~rx_mode;
  assign tx_valid_o  = tx_fire;
  assign tx_byte_o   = mem_rdata_i[15:8];
  assign lb_push_o   = tx_fire & loopback_i;
  assign lb_byte_o   = mem_rdata_i[15:8];

endmodule

// File: rtl/scc_dma_checker.sv
`timescale 1ns/1ps
module scc_dma_checker #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ready_i,
  input logic          tx_valid_o,
  input logic [7:0]    tx_byte_o,
  input logic          loopback_i,
  input logic          rxq_nonempty_i,
  input logic [7:0]    rxq_data_i,
  input logic          rxq_pop_o,
  input logic          lb_push_o,
  input logic [7:0]    lb_byte_o,
  input logic          done_o,
  input logic [CW-1:0] byte_count_o,
  input logic          step_evt,
  input logic          wrap_evt,
  input logic          poll_now
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_tx_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> mem_req_o && !mem_we_o && mem_ready_i);

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ready_i |=> mem_addr_o == $past(mem_addr_o) + AW'(4));

  assert_wrap_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && wrap_evt |=> done_o);

  assert_loopback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lb_push_o |-> tx_valid_o && loopback_i && (lb_byte_o == tx_byte_o));

  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop_o |-> rxq_nonempty_i);

  assert_store_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop_o |=> mem_req_o && mem_we_o && (mem_wdata_o[7:0] == $past(rxq_data_i))
                  && (mem_wdata_o[31:24] == $past(rxq_data_i)));

  assert_empty_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_now && !rxq_nonempty_i |=> done_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(byte_count_o));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_o, rxq_pop_o, done_o}));

endmodule

bind scc_page_dma scc_dma_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_ready_i    (mem_ready_i),
  .tx_valid_o     (tx_valid_o),
  .tx_byte_o      (tx_byte_o),
  .loopback_i     (loopback_i),
  .rxq_nonempty_i (rxq_nonempty_i),
  .rxq_data_i     (rxq_data_i),
  .rxq_pop_o      (rxq_pop_o),
  .lb_push_o      (lb_push_o),
  .lb_byte_o      (lb_byte_o),
  .done_o         (done_o),
  .byte_count_o   (byte_count_o),
  .step_evt       (step_evt),
  .wrap_evt       (wrap_evt),
  .poll_now       (poll_now)
);

// File: tb/scc_page_dma_bench.sv
`timescale 1ns/1ps
module scc_page_dma_bench;
  localparam int AW = 32;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          dir_rx_i = 1'b0;
  logic          loopback_i = 1'b0;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic [31:0]   mem_rdata_i = '0;
  logic          mem_ready_i = 1'b0;
  logic          tx_valid_o;
  logic [7:0]    tx_byte_o;
  logic          rxq_nonempty_i = 1'b0;
  logic [7:0]    rxq_data_i = '0;
  logic          rxq_pop_o, lb_push_o;
  logic [7:0]    lb_byte_o;
  logic          done_o;
  logic [CW-1:0] byte_count_o;

  scc_page_dma u_scc_page_dma (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] q_mem [0:63];
  int q_len = 0, q_head = 0, n_words = 0;
  bit pend_pop = 0, done_seen = 0, exp_dir = 0, exp_lb = 0, running = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [CW-1:0] done_count = '0;

  function automatic logic [31:0] pattern(input logic [AW-1:0] a);
    return a * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction
  function automatic int tx_expect(input logic [AW-1:0] a);
    return 1024 - int'(a[11:2]);
  endfunction
  function automatic int rx_expect(input logic [AW-1:0] a, input int n);
    int room;
    room = 512 - int'(a[10:2]);
    return (n < room) ? n : room;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory and queue responder, active at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (pend_pop) begin q_head++; pend_pop = 0; end
      rxq_nonempty_i = q_head < q_len;
      rxq_data_i     = q_mem[q_head[5:0]];
      mem_ready_i    = ($urandom % 4) != 0;
      mem_rdata_i    = pattern(mem_addr_o);
      #1;
      if (rxq_pop_o) pend_pop = 1;
      if (running && mem_req_o && mem_ready_i) begin
        chk(mem_addr_o == exp_addr, exp_dir ? "R8 rx address" : "R4 tx address", mem_addr_o, exp_addr);
        if (!exp_dir) begin
          chk(!mem_we_o, "R3 read", 32'(mem_we_o), 0);
          chk(tx_valid_o && tx_byte_o == mem_rdata_i[15:8], "R3 lane1", {tx_valid_o, tx_byte_o},
              {1'b1, mem_rdata_i[15:8]});
          chk(lb_push_o == exp_lb && (!exp_lb || lb_byte_o == mem_rdata_i[15:8]), "R5 loopback",
              {lb_push_o, lb_byte_o}, {exp_lb, mem_rdata_i[15:8]});
        end else begin
          chk(mem_we_o && mem_wdata_o == {4{q_mem[n_words[5:0]]}}, "R6 store",
              mem_wdata_o, {4{q_mem[n_words[5:0]]}});
        end
        exp_addr = exp_addr + 4;
        n_words++;
      end else if (tx_valid_o || lb_push_o) begin
        chk(0, "R3 stray strobe", {tx_valid_o, lb_push_o}, 0);
      end
      if (done_o && !done_seen) begin
        done_seen  = 1;
        done_count = byte_count_o;
      end
    end
  end

  task automatic run(input logic [AW-1:0] a, input bit rx, input bit lb, input int qn, input bit intrude);
    int exp_words;
    for (int i = 0; i < 64; i++) q_mem[i] = 8'($urandom);
    @(negedge clk);
    q_len = qn; q_head = 0; pend_pop = 0;
    exp_addr = {a[AW-1:2], 2'b00};
    exp_dir = rx; exp_lb = lb; n_words = 0; done_seen = 0; running = 1;
    exp_words = rx ? rx_expect(a, qn) : tx_expect(a);
    start_i = 1; start_addr_i = a; dir_rx_i = rx; loopback_i = lb;
    @(negedge clk);
    start_i = 0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      if (!done_seen) begin
        start_i = 1; start_addr_i = 32'h0000_0100; dir_rx_i = ~rx;
        @(negedge clk);
        start_i = 0; dir_rx_i = rx;
      end
    end
    while (!done_seen) @(negedge clk);
    #2;
    chk(n_words == exp_words, rx ? "R7/R8 word count" : "R4 word count", n_words, exp_words);
    chk(done_count == CW'(rx ? exp_words * 4 : exp_words), "R9 byte count", done_count,
        rx ? exp_words * 4 : exp_words);
    if (intrude) chk(n_words == exp_words, "R10 start ignored while busy", n_words, exp_words);
    @(negedge clk);
    #2;
    chk(!done_o, "R10 done one cycle", 32'(done_o), 0);
    chk(byte_count_o == done_count, "R9 count held", byte_count_o, done_count);
    running = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    chk(!mem_req_o && !rxq_pop_o && !done_o && !tx_valid_o && byte_count_o == '0, "R1 reset state",
        {mem_req_o, rxq_pop_o, done_o, tx_valid_o}, 0);
    // directed corner cases
    run(32'h0000_1000, 0, 0, 0, 0);   // full 4 KB page: 1024 words
    run(32'h0000_2FF3, 0, 1, 0, 0);   // unaligned start (R2), last 4 words, loopback
    run(32'h0000_3F80, 0, 1, 0, 1);   // 32 words with a stray start
    run(32'h0000_0800, 1, 0, 0, 0);   // empty queue: no writes
    run(32'h0000_0800, 1, 0, 10, 0);  // queue empties first
    run(32'h0000_07F8, 1, 0, 10, 0);  // half-page stop after 2 words
    run(32'h0000_4000, 1, 0, 20, 1);  // stray start during receive
    // random transfers
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] a;
      bit rx;
      rx = 1'($urandom);
      if (rx) a = 32'h0001_0000 + ((512 - 1 - ($urandom % 40)) << 2) + ($urandom % 4);
      else    a = 32'h0002_0000 + ((1024 - 1 - ($urandom % 40)) << 2) + ($urandom % 4);
      run(a, rx, 1'($urandom), int'($urandom % 41), 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule